// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the clock set that an external audio DAC needs, starting from a single PLL clock. A programmable divider turns the PLL clock into the audio master clock. The master clock leaves the block as the DAC system clock. The same master clock is then divided again into a serial bit clock and a left/right word-select clock.

Two settings pick the bit-clock divider. The first fixes the ratio of master clock to sample rate at 256 or 384. The second gives each channel 16 or 32 bit periods. A polarity input picks whether the left channel is the low or the high phase of word select.

While the data source reports that no sample is ready, the bit and word generation pauses in place, and its outputs do not toggle. One-cycle strobes mark each falling edge of the bit clock and the start of each frame, so that a serializer in the PLL clock domain can change its data on the falling edge.

Top module: `audclk_gen`

## Requirements
- R1: With divide field D (0..31), the system clock output repeats every D+1 PLL cycles. In each period it is high for the first (D+2)/2 cycles (integer division) and low for the rest. With D=0 it is therefore held high.
- R2: The system clock output is high in the first PLL cycle after enable is sampled high. When enable is sampled low, every output is low from the next cycle on. All counters restart from zero, with the bit clock low and the left channel first.
- R3: The bit clock starts low and toggles every H master periods, so it has a 50% duty cycle. H is 4, 2, 6 or 3 for (ratio, slot) = (256, 16), (256, 32), (384, 16) and (384, 32). Consecutive falling edges are therefore 2·H·(D+1) PLL cycles apart.
- R4: Word select changes only together with a falling edge of the bit clock. It changes once every 16 or 32 bit periods, as the slot-size input selects (0 = 16, 1 = 32).
- R5: Internally the channel is 0 for left and 1 for right, and word select equals channel XOR polarity. With polarity 0 the left channel is sent while word select is low; with polarity 1 it is sent while word select is high.
- R6: While the data-ready input is sampled low, the bit clock and word select hold their levels and no strobe is given. The system clock keeps running. When data-ready returns high, generation resumes from the point where it paused.
- R7: The bit strobe is high for exactly the one PLL cycle in which the bit clock output has just fallen, and for no other cycle.
- R8: The frame strobe is high together with the bit strobe at the falling edge where word select returns to the left channel. Frame strobes are 256·(D+1) or 384·(D+1) PLL cycles apart, following the ratio input (0 = 256, 1 = 384).
- R9: During reset, and while the block is disabled, all five outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PLL clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aud_en_i | input | 1 | Audio enable |
| div_i | input | 5 | Master divide field D; master clock = PLL / (D+1) |
| rate384_i | input | 1 | Master-to-sample ratio: 0 = 256, 1 = 384 |
| slot32_i | input | 1 | Bit periods per channel: 0 = 16, 1 = 32 |
| ws_pol_i | input | 1 | Word-select polarity: 0 = left low, 1 = left high |
| data_rdy_i | input | 1 | Sample data available at the converter input |
| sys_clk_o | output | 1 | DAC system (master) clock |
| bit_clk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select (left/right) |
| bit_stb_o | output | 1 | One-cycle strobe at each bit-clock falling edge |
| frame_stb_o | output | 1 | One-cycle strobe at each frame start |

## Verification
The bench covers all four ratio/slot pairs, including the odd half-period of 3 master periods, and runs the divider at its extremes D=0 and D=31. A divider with an off-by-one wrap would show up as wrong bit and frame spacing, and a wrong D=0 rule would make the system clock toggle instead of staying high. A pause on data-ready is applied in the middle of a frame. A design that only gated the output pins, rather than freezing its state, would either toggle the bit clock during the pause or resume at a shifted phase. Enable is dropped and raised again, and both polarities are checked at frame starts, so a generator that did not restart on the left channel, or that inverted polarity, produces the wrong word-select level at the frame strobe.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int DIV_W  = 5;
  localparam int HIGH_W = DIV_W + 1;
  localparam int HALF_W = 3;
  localparam int BIT_W  = 6;

  // master periods per bit-clock half period
  function automatic logic [HALF_W-1:0] half_bit_len(input logic r384, input logic s32);
    int per_sample;
    int per_bit;
    per_sample = r384 ? 384 : 256;
    per_bit    = per_sample / (s32 ? 64 : 32);
    return HALF_W'(per_bit / 2);
  endfunction

  // bit periods in one channel slot
  function automatic logic [BIT_W-1:0] slot_bits(input logic s32);
    return s32 ? BIT_W'(32) : BIT_W'(16);
  endfunction

  // PLL cycles per master period in which the system clock is high
  function automatic logic [HIGH_W-1:0] sys_high_len(input logic [DIV_W-1:0] d);
    return (HIGH_W'(d) + HIGH_W'(2)) >> 1;
  endfunction
endpackage

// File: rtl/audclk_mdiv.sv
module audclk_mdiv
  import audclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             run_o,
  output logic             mtick_o,
  output logic             sys_clk_o
);
  logic             run_q;
  logic [DIV_W-1:0] cnt_q;

  assign mtick_o   = run_q && (cnt_q >= div_i);
  assign sys_clk_o = run_q && ({1'b0, cnt_q} < sys_high_len(div_i));
  assign run_o     = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) cnt_q <= mtick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/audclk_bitgen.sv
module audclk_bitgen
  import audclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic step_i,
  input  logic rate384_i,
  input  logic slot32_i,
  output logic bit_clk_o,
  output logic fall_o,
  output logic bit_stb_o
);
  logic [HALF_W-1:0] hcnt_q;
  logic [HALF_W-1:0] half_len;
  logic              last_half;
  logic              bclk_q;
  logic              stb_q;

  assign half_len  = half_bit_len(rate384_i, slot32_i);
  assign last_half = hcnt_q >= (half_len - HALF_W'(1));
  assign fall_o    = step_i && last_half && bclk_q;
  assign bit_clk_o = bclk_q;
  assign bit_stb_o = stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      bclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else if (!en_i) begin
      hcnt_q <= '0;
      bclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= fall_o;
      if (step_i) begin
        if (last_half) begin
          hcnt_q <= '0;
          bclk_q <= ~bclk_q;
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audclk_wordgen.sv
module audclk_wordgen
  import audclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  input  logic fall_i,
  input  logic slot32_i,
  input  logic ws_pol_i,
  output logic ws_o,
  output logic frame_stb_o
);
  logic [BIT_W-1:0] bcnt_q;
  logic             right_q;
  logic             fstb_q;
  logic             slot_end;

  assign slot_end    = bcnt_q >= (slot_bits(slot32_i) - BIT_W'(1));
  assign ws_o        = run_i && (right_q ^ ws_pol_i);
  assign frame_stb_o = fstb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q  <= '0;
      right_q <= 1'b0;
      fstb_q  <= 1'b0;
    end else if (!en_i) begin
      bcnt_q  <= '0;
      right_q <= 1'b0;
      fstb_q  <= 1'b0;
    end else begin
      fstb_q <= fall_i && slot_end && right_q;
      if (fall_i) begin
        if (slot_end) begin
          bcnt_q  <= '0;
          right_q <= ~right_q;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             aud_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rate384_i,
  input  logic             slot32_i,
  input  logic             ws_pol_i,
  input  logic             data_rdy_i,
  output logic             sys_clk_o,
  output logic             bit_clk_o,
  output logic             ws_o,
  output logic             bit_stb_o,
  output logic             frame_stb_o
);
  logic run_en;
  logic mtick;
  logic bit_step;
  logic fall_evt;

  assign bit_step = mtick && data_rdy_i;

  audclk_mdiv mdiv_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (aud_en_i),
    .div_i    (div_i),
    .run_o    (run_en),
    .mtick_o  (mtick),
    .sys_clk_o(sys_clk_o)
  );

  audclk_bitgen bitgen_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (aud_en_i),
    .step_i    (bit_step),
    .rate384_i (rate384_i),
    .slot32_i  (slot32_i),
    .bit_clk_o (bit_clk_o),
    .fall_o    (fall_evt),
    .bit_stb_o (bit_stb_o)
  );

  audclk_wordgen wordgen_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (aud_en_i),
    .run_i      (run_en),
    .fall_i     (fall_evt),
    .slot32_i   (slot32_i),
    .ws_pol_i   (ws_pol_i),
    .ws_o       (ws_o),
    .frame_stb_o(frame_stb_o)
  );
endmodule

// File: rtl/audclk_chk.sv
module audclk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic aud_en_i,
  input logic data_rdy_i,
  input logic ws_pol_i,
  input logic run_i,
  input logic fall_i,
  input logic sys_clk_i,
  input logic bit_clk_i,
  input logic ws_i,
  input logic bit_stb_i,
  input logic frame_stb_i
);
  // R7
  bit_stb_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_i |-> (!bit_clk_i && $past(bit_clk_i)));

  // R7
  fall_has_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bit_clk_i) && $past(aud_en_i)) |-> bit_stb_i);

  // R7
  fall_evt_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && aud_en_i) |=> bit_stb_i);

  // R8
  frame_in_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i |-> bit_stb_i);

  // R4
  ws_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && run_i && $stable(ws_pol_i) && !$stable(ws_i)) |-> bit_stb_i);

  // R6
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && run_i && !$past(data_rdy_i)) |-> ($stable(bit_clk_i) && !bit_stb_i));

  // R9
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !(sys_clk_i || bit_clk_i || ws_i || bit_stb_i || frame_stb_i));
endmodule

bind audclk_gen audclk_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .aud_en_i   (aud_en_i),
  .data_rdy_i (data_rdy_i),
  .ws_pol_i   (ws_pol_i),
  .run_i      (run_en),
  .fall_i     (fall_evt),
  .sys_clk_i  (sys_clk_o),
  .bit_clk_i  (bit_clk_o),
  .ws_i       (ws_o),
  .bit_stb_i  (bit_stb_o),
  .frame_stb_i(frame_stb_o)
);

// File: tb/audclk_gen_tb_top.sv
module audclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aud_en = 1'b0;
  logic [4:0] div = 5'd0;
  logic       rate384 = 1'b0;
  logic       slot32 = 1'b0;
  logic       ws_pol = 1'b0;
  logic       data_rdy = 1'b0;
  logic       sys_clk, bit_clk, ws, bit_stb, frame_stb;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audclk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .aud_en_i(aud_en), .div_i(div),
    .rate384_i(rate384), .slot32_i(slot32), .ws_pol_i(ws_pol),
    .data_rdy_i(data_rdy), .sys_clk_o(sys_clk), .bit_clk_o(bit_clk),
    .ws_o(ws), .bit_stb_o(bit_stb), .frame_stb_o(frame_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_en, m_bclk, m_right, m_bstb, m_fstb;
  int m_div, m_half, m_bits;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !aud_en) begin
      m_en = 0; m_div = 0; m_half = 0; m_bclk = 0;
      m_bits = 0; m_right = 0; m_bstb = 0; m_fstb = 0;
    end else begin
      bit tick;
      int halfp, slot;
      tick = m_en && (m_div >= int'(div));
      halfp = ((rate384 ? 384 : 256) / (slot32 ? 64 : 32)) / 2;
      slot = slot32 ? 32 : 16;
      m_bstb = 0;
      m_fstb = 0;
      if (tick && data_rdy) begin
        if (m_half + 1 >= halfp) begin
          m_half = 0;
          if (m_bclk) begin
            m_bstb = 1;
            if (m_bits + 1 >= slot) begin
              m_bits = 0;
              if (m_right) m_fstb = 1;
              m_right = !m_right;
            end else m_bits++;
          end
          m_bclk = !m_bclk;
        end else m_half++;
      end
      m_div = m_en ? (tick ? 0 : m_div + 1) : 0;
      m_en = 1;
    end
  end

  // per-cycle comparison and spacing measurement
  int cyc = 0;
  int last_b = -1;
  int last_f = -1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      bit e_sys, e_ws;
      int mult;
      e_sys = m_en && (m_div < (int'(div) + 2) / 2);
      e_ws  = m_en && (m_right ^ ws_pol);
      chk(sys_clk == e_sys, "R1 system clock", sys_clk, e_sys);
      chk(bit_clk == m_bclk, "R3 bit clock", bit_clk, m_bclk);
      chk(ws == e_ws, "R4 word select", ws, e_ws);
      chk(bit_stb == m_bstb, "R7 bit strobe", bit_stb, m_bstb);
      chk(frame_stb == m_fstb, "R8 frame strobe", frame_stb, m_fstb);
      mult = int'(div) + 1;
      if (!aud_en || !data_rdy) begin
        last_b = -1;
        last_f = -1;
      end else begin
        if (bit_stb) begin
          if (last_b >= 0)
            chk(cyc - last_b == 2 * (((rate384 ? 384 : 256) / (slot32 ? 64 : 32)) / 2) * mult,
                "R3 bit period", cyc - last_b,
                2 * (((rate384 ? 384 : 256) / (slot32 ? 64 : 32)) / 2) * mult);
          last_b = cyc;
        end
        if (frame_stb) begin
          chk(ws == ws_pol, "R5 left level at frame start", ws, ws_pol);
          if (last_f >= 0)
            chk(cyc - last_f == (rate384 ? 384 : 256) * mult, "R8 frame period",
                cyc - last_f, (rate384 ? 384 : 256) * mult);
          last_f = cyc;
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start_cfg(input int d, input bit r, input bit s, input bit p);
    aud_en = 0;
    wait_cyc(2);
    div = 5'(d); rate384 = r; slot32 = s; ws_pol = p; data_rdy = 1;
    aud_en = 1;
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R9: outputs low in reset
    #20;
    chk({sys_clk, bit_clk, ws, bit_stb, frame_stb} == 5'b0, "R9 reset outputs",
        {sys_clk, bit_clk, ws, bit_stb, frame_stb}, 0);
    #1 rst_n = 1;
    wait_cyc(3);
    chk({sys_clk, bit_clk, ws, bit_stb, frame_stb} == 5'b0, "R9 disabled outputs",
        {sys_clk, bit_clk, ws, bit_stb, frame_stb}, 0);

    // R2: system clock high one cycle after enable
    start_cfg(1, 0, 0, 0);
    wait_cyc(1);
    @(negedge clk);
    chk(sys_clk == 1'b1, "R2 system clock after enable", sys_clk, 1);
    wait_cyc(3000);

    // R2: disable forces all outputs low
    aud_en = 0;
    wait_cyc(1);
    @(negedge clk);
    chk({sys_clk, bit_clk, ws, bit_stb, frame_stb} == 5'b0, "R2 disable clears outputs",
        {sys_clk, bit_clk, ws, bit_stb, frame_stb}, 0);

    start_cfg(3, 1, 0, 1);
    wait_cyc(4000);

    // R1: D=0 keeps system clock high
    start_cfg(0, 0, 1, 0);
    wait_cyc(5);
    begin
      int lows = 0;
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        if (!sys_clk) lows++;
      end
      chk(lows == 0, "R1 D=0 system clock held high", lows, 0);
    end

    // R6: pause mid-frame
    start_cfg(2, 1, 1, 1);
    wait_cyc(2000);
    data_rdy = 0;
    wait_cyc(1);
    @(negedge clk);
    begin
      bit b0, w0;
      int moves = 0;
      int stbs = 0;
      int sys_toggles = 0;
      bit sprev;
      b0 = bit_clk; w0 = ws; sprev = sys_clk;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (bit_clk != b0 || ws != w0) moves++;
        if (bit_stb || frame_stb) stbs++;
        if (sys_clk != sprev) sys_toggles++;
        sprev = sys_clk;
      end
      chk(moves == 0, "R6 clocks frozen while paused", moves, 0);
      chk(stbs == 0, "R6 no strobes while paused", stbs, 0);
      chk(sys_toggles > 0, "R6 system clock keeps running", sys_toggles, 1);
    end
    #1 data_rdy = 1;
    wait_cyc(3000);

    // largest divider, then odd half period
    start_cfg(31, 0, 0, 0);
    wait_cyc(20000);
    start_cfg(4, 1, 1, 0);
    wait_cyc(6000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule